// File: doc/BRIEF.md
# SD/MMC Host Command Issue and Response Capture

This block is the command half of an SD/MMC host controller. Software writes a 16-bit command word whose fields carry the command index and its attributes: response type, busy flag, command class, init request and data direction. Once the controller is enabled, the block hands the index and a 32-bit argument to a card-side command engine. It then holds its request until that engine reports completion.

The card side returns up to 16 response bytes, one per valid strobe, followed by a done strobe that carries the response byte count. One cycle later the block classifies the response by the type that was expected. A response that is too short is reported as a timeout. For the normal card-status response it also tests the card-status error bits. Finally it packs the bytes into eight readable 16-bit response registers and raises the end-of-command status bits.

A data-class command also pulses a start signal to the transfer engine, which empties that engine's FIFO. At the same time the block marks a transfer as active and latches its direction.

Top module: `sdhc_cmd_path`

## Requirements
- R1: While `host_enable` is low, a write to the command register (address 0) has no effect: the command readback, the response registers, `card_req` and the transfer outputs all keep their values.
- R2: An accepted command write stores the word, which reads back at address 0. In the cycle after the write, all eight response registers (addresses 8 to 15) read zero.
- R3: A command with bit 7 set and index bits 5:0 equal to zero makes no card request. It only sets status bit 0.
- R4: Address 1 holds the low 16 bits of the argument and address 2 holds the high 16 bits. Each reads back on its own. `card_arg` presents {high, low} and `card_idx` presents command bits 5:0.
- R5: Response type field bits 10:8 select how many bytes are needed: 1, 3 and 6 need at least 4, 2 needs 16, and every other value needs none. A byte count below the need sets status bit 7 and not bit 0.
- R6: Response type 1 with busy bit 11 set obeys the same length and error rules as type 1 without it.
- R7: For type 1, bytes 0 to 3 form a big-endian 32-bit card status. If it has any bit of mask 0xFDF90000 set, status bit 14 is set. In every other case status bit 14 is cleared at the end of the command.
- R8: When a response is kept (a needed length that was met), response register 7−k receives {byte 2k, byte 2k+1}, and bytes not received read as zero. With no response expected, or after a timeout, all eight registers stay zero.
- R9: A command with index 12 that completes without timeout sets status bits 0 and 2. Any other command that completes without timeout sets only bit 0.
- R10: A command with class bits 13:12 equal to 1 pulses `xfer_start` for one cycle, sets `xfer_active` and latches bit 15 into `xfer_dir`. Any other issued class clears `xfer_active`, and so does `xfer_end`.
- R11: Writing the status register (address 3) clears each bit written as 1. A status bit set by a completing command in the same cycle stays set.
- R12: `card_req` rises in the cycle after an accepted write and is held until `card_done`. Status changes one cycle after `card_done`. Command writes made while `cmd_busy` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_enable | input | 1 | Controller enable from the control register |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` |
| cmd_busy | output | 1 | A command is in flight |
| cmd_status | output | 16 | Status register |
| card_req | output | 1 | Command request to the card side |
| card_idx | output | 6 | Command index |
| card_arg | output | 32 | Command argument |
| rsp_valid | input | 1 | Response byte strobe |
| rsp_byte | input | 8 | Response byte, first byte first |
| card_done | input | 1 | Card side finished the command |
| rsp_count | input | 5 | Response bytes delivered, valid with `card_done` |
| xfer_start | output | 1 | One-cycle pulse: empty the FIFO and start the transfer |
| xfer_active | output | 1 | Transfer in progress |
| xfer_dir | output | 1 | Transfer direction, 1 = read from card |
| xfer_end | input | 1 | Transfer engine reports completion |

## Verification
The assertions assume the card side raises `card_done` only while `card_req` is high, and only after every `rsp_valid` byte has been delivered. They also assume it never sends more bytes than `rsp_count` reports. The bench's reply task keeps to this contract: it waits for `card_req`, streams exactly the bytes it will count, and then pulses `card_done` once. Register writes are applied one at a time at the falling edge. The sweep covers every response-type code, both busy values and lengths on either side of each needed length. It computes the expected status and the packed registers from the byte pattern it sent.

// File: rtl/sdhc_cmd_pkg.sv
package sdhc_cmd_pkg;

    typedef enum logic [1:0] {
        CS_IDLE = 2'd0,
        CS_WAIT = 2'd1,
        CS_EVAL = 2'd2
    } cmd_state_e;

    localparam int REG_W = 16;

    localparam logic [3:0] A_CMD  = 4'd0;
    localparam logic [3:0] A_ARGL = 4'd1;
    localparam logic [3:0] A_ARGH = 4'd2;
    localparam logic [3:0] A_STAT = 4'd3;
    localparam int         A_RSP0 = 8;

    localparam int F_INIT   = 7;
    localparam int F_RT_LSB = 8;
    localparam int F_BUSY   = 11;
    localparam int F_CT_LSB = 12;
    localparam int F_DIR    = 15;

    localparam logic [2:0] RT_R1 = 3'd1;
    localparam logic [2:0] RT_R2 = 3'd2;
    localparam logic [2:0] RT_R3 = 3'd3;
    localparam logic [2:0] RT_R6 = 3'd6;

    localparam logic [1:0] CT_DATA = 2'd1;

    localparam int S_DONE = 0;
    localparam int S_STOP = 2;
    localparam int S_TMO  = 7;
    localparam int S_CERR = 14;

    localparam logic [5:0]  IDX_STOP      = 6'd12;
    localparam logic [31:0] CARD_ERR_MASK = 32'hFDF9_0000;

endpackage

// File: rtl/sdhc_rsp_bytes.sv
module sdhc_rsp_bytes #(
    parameter int NB = 16,
    localparam int PW = $clog2(NB + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               wr_en,
    input  logic [7:0]         wr_byte,
    output logic [NB-1:0][7:0] bytes_o
);

    logic [NB-1:0][7:0] mem_d, mem_q;
    logic [PW-1:0]      ptr_d, ptr_q;

    always_comb begin
        mem_d = mem_q;
        ptr_d = ptr_q;
        if (clr) begin
            mem_d = '0;
            ptr_d = '0;
        end else if (wr_en && (ptr_q < PW'(NB))) begin
            for (int i = 0; i < NB; i++) begin
                if (ptr_q == PW'(i)) mem_d[i] = wr_byte;
            end
            ptr_d = ptr_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_q <= '0;
            ptr_q <= '0;
        end else begin
            mem_q <= mem_d;
            ptr_q <= ptr_d;
        end
    end

    assign bytes_o = mem_q;

endmodule

// File: rtl/sdhc_rsp_check.sv
module sdhc_rsp_check
    import sdhc_cmd_pkg::*;
#(
    parameter int CNT_W    = 5,
    parameter int LONG_LEN = 16
) (
    input  logic [2:0]       rtype,
    input  logic             busy_flag,
    input  logic [CNT_W-1:0] rcount,
    input  logic [31:0]      card_word,
    output logic             timeout,
    output logic             card_err,
    output logic             keep
);

    localparam int SHORT_LEN = 4;

    logic [CNT_W-1:0] need;
    logic             plain_r1, r1_busy;

    always_comb begin
        plain_r1 = (rtype == RT_R1) && !busy_flag;
        r1_busy  = (rtype == RT_R1) && busy_flag;
        case (rtype)
            RT_R1, RT_R3, RT_R6: need = CNT_W'(SHORT_LEN);
            RT_R2:               need = CNT_W'(LONG_LEN);
            default:             need = '0;
        endcase
        timeout  = (need != '0) && (rcount < need);
        keep     = (need != '0) && !timeout;
        card_err = (plain_r1 || r1_busy) && !timeout
                   && ((card_word & CARD_ERR_MASK) != 32'd0);
    end

endmodule

// File: rtl/sdhc_cmd_path.sv
module sdhc_cmd_path
    import sdhc_cmd_pkg::*;
#(
    parameter int RSP_BYTES = 16,
    localparam int CNT_W = $clog2(RSP_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_enable,
    input  logic             reg_we,
    input  logic [3:0]       reg_addr,
    input  logic [15:0]      reg_wdata,
    output logic [15:0]      reg_rdata,
    output logic             cmd_busy,
    output logic [15:0]      cmd_status,
    output logic             card_req,
    output logic [5:0]       card_idx,
    output logic [31:0]      card_arg,
    input  logic             rsp_valid,
    input  logic [7:0]       rsp_byte,
    input  logic             card_done,
    input  logic [CNT_W-1:0] rsp_count,
    output logic             xfer_start,
    output logic             xfer_active,
    output logic             xfer_dir,
    input  logic             xfer_end
);

    localparam int N_REGS = RSP_BYTES / 2;

    typedef struct packed {
        cmd_state_e                    st;
        logic [REG_W-1:0]              cmd;
        logic [REG_W-1:0]              arg_lo;
        logic [REG_W-1:0]              arg_hi;
        logic [REG_W-1:0]              stat;
        logic [N_REGS-1:0][REG_W-1:0]  rsp;
        logic                          req;
        logic [CNT_W-1:0]              cnt;
        logic                          xact;
        logic                          xdir;
        logic                          xstart;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [RSP_BYTES-1:0][7:0] rb;
    logic                      accept, init_zero, buf_clr, buf_wr;
    logic                      chk_tmo, chk_err, chk_keep;

    assign accept    = reg_we && (reg_addr == A_CMD) && host_enable && (ctl_q.st == CS_IDLE);
    assign init_zero = reg_wdata[F_INIT] && (reg_wdata[5:0] == 6'd0);
    assign buf_clr   = accept && !init_zero;
    assign buf_wr    = rsp_valid && (ctl_q.st == CS_WAIT);

    sdhc_rsp_bytes #(.NB(RSP_BYTES)) u_bytes (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (buf_clr),
        .wr_en   (buf_wr),
        .wr_byte (rsp_byte),
        .bytes_o (rb)
    );

    sdhc_rsp_check #(.CNT_W(CNT_W), .LONG_LEN(RSP_BYTES)) u_check (
        .rtype     (ctl_q.cmd[F_RT_LSB +: 3]),
        .busy_flag (ctl_q.cmd[F_BUSY]),
        .rcount    (ctl_q.cnt),
        .card_word ({rb[0], rb[1], rb[2], rb[3]}),
        .timeout   (chk_tmo),
        .card_err  (chk_err),
        .keep      (chk_keep)
    );

    always_comb begin
        ctl_d        = ctl_q;
        ctl_d.xstart = 1'b0;

        if (reg_we && (reg_addr == A_ARGL)) ctl_d.arg_lo = reg_wdata;
        if (reg_we && (reg_addr == A_ARGH)) ctl_d.arg_hi = reg_wdata;
        if (reg_we && (reg_addr == A_STAT)) ctl_d.stat   = ctl_q.stat & ~reg_wdata;
        if (xfer_end) ctl_d.xact = 1'b0;

        case (ctl_q.st)
            CS_IDLE: begin
                if (accept) begin
                    ctl_d.cmd = reg_wdata;
                    ctl_d.rsp = '0;
                    if (init_zero) begin
                        ctl_d.stat[S_DONE] = 1'b1;
                    end else begin
                        ctl_d.st  = CS_WAIT;
                        ctl_d.req = 1'b1;
                        if (reg_wdata[F_CT_LSB +: 2] == CT_DATA) begin
                            ctl_d.xact   = 1'b1;
                            ctl_d.xdir   = reg_wdata[F_DIR];
                            ctl_d.xstart = 1'b1;
                        end else begin
                            ctl_d.xact = 1'b0;
                        end
                    end
                end
            end
            CS_WAIT: begin
                if (card_done) begin
                    ctl_d.req = 1'b0;
                    ctl_d.cnt = rsp_count;
                    ctl_d.st  = CS_EVAL;
                end
            end
            CS_EVAL: begin
                ctl_d.stat[S_CERR] = chk_err;
                if (chk_tmo) begin
                    ctl_d.stat[S_TMO] = 1'b1;
                end else begin
                    ctl_d.stat[S_DONE] = 1'b1;
                    if (ctl_q.cmd[5:0] == IDX_STOP) ctl_d.stat[S_STOP] = 1'b1;
                end
                if (chk_keep) begin
                    for (int k = 0; k < N_REGS; k++) begin
                        ctl_d.rsp[N_REGS-1-k] = {rb[2*k], rb[2*k+1]};
                    end
                end
                ctl_d.st = CS_IDLE;
            end
            default: ctl_d.st = CS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CMD:   reg_rdata = ctl_q.cmd;
            A_ARGL:  reg_rdata = ctl_q.arg_lo;
            A_ARGH:  reg_rdata = ctl_q.arg_hi;
            A_STAT:  reg_rdata = ctl_q.stat;
            default: begin
                for (int k = 0; k < N_REGS; k++) begin
                    if (reg_addr == 4'(A_RSP0 + k)) reg_rdata = ctl_q.rsp[k];
                end
            end
        endcase
    end

    assign cmd_busy    = (ctl_q.st != CS_IDLE);
    assign cmd_status  = ctl_q.stat;
    assign card_req    = ctl_q.req;
    assign card_idx    = ctl_q.cmd[5:0];
    assign card_arg    = {ctl_q.arg_hi, ctl_q.arg_lo};
    assign xfer_start  = ctl_q.xstart;
    assign xfer_active = ctl_q.xact;
    assign xfer_dir    = ctl_q.xdir;

endmodule

// File: rtl/sdhc_cmd_path_chk.sv
module sdhc_cmd_path_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        host_enable,
    input logic        reg_we,
    input logic [3:0]  reg_addr,
    input logic [15:0] reg_wdata,
    input logic        cmd_busy,
    input logic [15:0] cmd_status,
    input logic        card_req,
    input logic        card_done,
    input logic        xfer_start,
    input logic        xfer_dir
);

    logic cmd_wr, acc, init0;

    assign cmd_wr = reg_we && (reg_addr == 4'd0);
    assign acc    = cmd_wr && host_enable && !cmd_busy;
    assign init0  = reg_wdata[7] && (reg_wdata[5:0] == 6'd0);

    assert_disabled_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !host_enable && !cmd_busy) |=> (!card_req && !xfer_start));

    assert_init_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && init0) |=> (!card_req && cmd_status[0]));

    assert_data_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !init0 && (reg_wdata[13:12] == 2'd1))
        |=> (xfer_start && (xfer_dir == $past(reg_wdata[15]))));

    assert_req_held_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (card_req && !card_done) |=> card_req);

    assert_req_drop_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (card_req && card_done) |=> (!card_req && cmd_busy));

    assert_busy_ignored_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_busy) |=> !xfer_start);

endmodule

bind sdhc_cmd_path sdhc_cmd_path_chk u_chk (.*);

// File: tb/sim_sdhc_cmd_path.sv
module sim_sdhc_cmd_path;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_enable = 1'b1;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        cmd_busy;
    logic [15:0] cmd_status;
    logic        card_req;
    logic [5:0]  card_idx;
    logic [31:0] card_arg;
    logic        rsp_valid = 1'b0;
    logic [7:0]  rsp_byte = '0;
    logic        card_done = 1'b0;
    logic [4:0]  rsp_count = '0;
    logic        xfer_start, xfer_active, xfer_dir;
    logic        xfer_end = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] bb [16];

    always #4 clk = ~clk;

    sdhc_cmd_path u0 (.*);

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic reply(input int n);
        int g = 0;
        while (!card_req && g < 100) begin
            @(negedge clk);
            g++;
        end
        for (int i = 0; i < n; i++) begin
            rsp_valid = 1'b1; rsp_byte = bb[i];
            @(negedge clk);
        end
        rsp_valid = 1'b0;
        card_done = 1'b1; rsp_count = 5'(n);
        @(negedge clk);
        card_done = 1'b0;
        @(negedge clk);
    endtask

    task automatic fill(input int seed, input int n);
        for (int i = 0; i < 16; i++) bb[i] = (i < n) ? 8'(seed * 37 + i * 29 + 5) : 8'h00;
    endtask

    task automatic check_rsp(input string tag, input logic keep);
        logic [15:0] v;
        for (int k = 0; k < 8; k++) begin
            rd(4'(8 + k), v);
            check(tag, {16'h0, v}, keep ? {16'h0, bb[2*(7-k)], bb[2*(7-k)+1]} : 32'h0);
        end
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] v;
        logic [15:0] cw;
        int lens [5] = '{0, 3, 4, 15, 16};
        int cs = 0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        rd(4'd3, v); check("R11 reset status", {16'h0, v}, 32'h0);
        check("R12 reset card_req", {31'h0, card_req}, 32'h0);
        check("R10 reset xfer_active", {31'h0, xfer_active}, 32'h0);

        // R4 argument halves
        wr(4'd1, 16'hBEEF);
        wr(4'd2, 16'h1234);
        rd(4'd1, v); check("R4 arg low", {16'h0, v}, 32'h0000BEEF);
        rd(4'd2, v); check("R4 arg high", {16'h0, v}, 32'h00001234);
        wr(4'd0, 16'h0011);
        check("R4 card_arg", card_arg, 32'h1234BEEF);
        check("R4 card_idx", {26'h0, card_idx}, 32'h11);
        rd(4'd0, v); check("R2 cmd readback", {16'h0, v}, 32'h0011);
        fill(0, 0); reply(0);

        // sweep: every response type, busy flag, length around need (R5 R6 R7 R8)
        for (int rt = 0; rt < 8; rt++) begin
            for (int bz = 0; bz < 2; bz++) begin
                for (int li = 0; li < 5; li++) begin
                    int n, need;
                    logic to, keep, err;
                    logic [31:0] exp;
                    cs++;
                    n = lens[li];
                    fill(cs, n);
                    wr(4'd3, 16'hFFFF);
                    cw = 16'((bz << 11) | (rt << 8) | 5);
                    wr(4'd0, cw);
                    reply(n);
                    need = (rt == 1 || rt == 3 || rt == 6) ? 4 : (rt == 2 ? 16 : 0);
                    to   = (need != 0) && (n < need);
                    keep = (need != 0) && !to;
                    err  = (rt == 1) && !to && (({bb[0], bb[1], bb[2], bb[3]} & 32'hFDF90000) != 0);
                    exp  = to ? 32'h0080 : 32'h0001;
                    if (err) exp = exp | 32'h4000;
                    rd(4'd3, v);
                    check(bz ? "R6 R5 R7 status busy" : "R5 R7 status", {16'h0, v}, exp);
                    check_rsp("R8 packing", keep);
                end
            end
        end

        // R7 explicit card-status patterns
        wr(4'd3, 16'hFFFF);
        bb[0] = 8'h00; bb[1] = 8'h00; bb[2] = 8'h09; bb[3] = 8'h00;
        wr(4'd0, 16'h0105); reply(4);
        rd(4'd3, v); check("R7 no error bits", {16'h0, v}, 32'h0001);
        bb[1] = 8'h01; bb[2] = 8'h00;
        wr(4'd0, 16'h0105); reply(4);
        rd(4'd3, v); check("R7 error bit 16", {16'h0, v}, 32'h4001);
        bb[1] = 8'h02;
        wr(4'd0, 16'h0105); reply(4);
        rd(4'd3, v); check("R7 bit 17 not error, bit14 cleared", {16'h0, v}, 32'h0001);

        // R9 stop command
        wr(4'd3, 16'hFFFF);
        bb[0] = 8'h00; bb[1] = 8'h00; bb[2] = 8'h00; bb[3] = 8'h00;
        wr(4'd0, 16'h090C); reply(4);
        rd(4'd3, v); check("R9 index 12 status", {16'h0, v}, 32'h0005);
        wr(4'd3, 16'hFFFF);
        wr(4'd0, 16'h090C); reply(2);
        rd(4'd3, v); check("R9 index 12 timeout", {16'h0, v}, 32'h0080);

        // R3 init with index 0
        wr(4'd3, 16'hFFFF);
        wr(4'd0, 16'h0080);
        check("R3 no card_req", {31'h0, card_req}, 32'h0);
        rd(4'd3, v); check("R3 status bit0", {16'h0, v}, 32'h0001);

        // R11 write-one-to-clear selectivity
        wr(4'd3, 16'h0002);
        rd(4'd3, v); check("R11 clear other bit keeps bit0", {16'h0, v}, 32'h0001);
        wr(4'd3, 16'h0001);
        rd(4'd3, v); check("R11 clear bit0", {16'h0, v}, 32'h0000);

        // R2 + R1: fill response regs, then disabled write, then zeroing
        fill(99, 16);
        wr(4'd0, 16'h0207); reply(16);
        check_rsp("R8 long response", 1'b1);
        host_enable = 1'b0;
        wr(4'd0, 16'h0033);
        check("R1 no card_req", {31'h0, card_req}, 32'h0);
        rd(4'd0, v); check("R1 cmd unchanged", {16'h0, v}, 32'h0207);
        check_rsp("R1 rsp unchanged", 1'b1);
        host_enable = 1'b1;
        wr(4'd0, 16'h0008);
        check_rsp("R2 rsp zeroed", 1'b0);
        fill(0, 0); reply(0);
        check_rsp("R8 none type zero", 1'b0);

        // R10 data command
        wr(4'd0, 16'h9111);
        check("R10 xfer_start pulse", {31'h0, xfer_start}, 32'h1);
        check("R10 xfer_active", {31'h0, xfer_active}, 32'h1);
        check("R10 xfer_dir read", {31'h0, xfer_dir}, 32'h1);
        @(negedge clk);
        check("R10 xfer_start one cycle", {31'h0, xfer_start}, 32'h0);
        fill(5, 4); reply(4);
        check("R10 active after response", {31'h0, xfer_active}, 32'h1);
        wr(4'd0, 16'h0009);
        check("R10 other class clears active", {31'h0, xfer_active}, 32'h0);
        reply(0);
        wr(4'd0, 16'h1111);
        check("R10 xfer_dir write", {31'h0, xfer_dir}, 32'h0);
        reply(4);
        @(negedge clk); xfer_end = 1'b1;
        @(negedge clk); xfer_end = 1'b0;
        check("R10 xfer_end clears", {31'h0, xfer_active}, 32'h0);

        // R12 timing and busy-ignore
        wr(4'd3, 16'hFFFF);
        wr(4'd0, 16'h0015);
        check("R12 card_req raised", {31'h0, card_req}, 32'h1);
        wr(4'd0, 16'h1022);
        rd(4'd0, v); check("R12 write while busy ignored", {16'h0, v}, 32'h0015);
        check("R12 req held", {31'h0, card_req}, 32'h1);
        card_done = 1'b1; rsp_count = 5'd0;
        @(negedge clk);
        card_done = 1'b0;
        check("R12 req dropped", {31'h0, card_req}, 32'h0);
        rd(4'd3, v); check("R12 status not yet", {16'h0, v}, 32'h0000);
        @(negedge clk);
        rd(4'd3, v); check("R12 status one cycle after done", {16'h0, v}, 32'h0001);

        // R11 set wins over clear in the same cycle
        wr(4'd0, 16'h0015);
        card_done = 1'b1;
        @(negedge clk);
        card_done = 1'b0;
        reg_we = 1'b1; reg_addr = 4'd3; reg_wdata = 16'h0001;
        @(negedge clk);
        reg_we = 1'b0;
        rd(4'd3, v); check("R11 set wins over clear", {16'h0, v}, 32'h0001);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule